// File: doc/BRIEF.md
# Serial Receiver with Sticky Error Flags

This block turns an asynchronous serial line into characters. It uses a 16x oversampling tick supplied from outside. A falling edge on the idle-high line starts a character. The start bit is checked again at its midpoint. Data bits follow least significant bit first, each sampled at the middle of its own tick period. An optional parity bit comes next, and then the stop bit. A completed character is placed in a receive buffer, and a buffer-full flag is raised. Reading the buffer clears the flag.

Four error conditions are kept as sticky flags: overrun, framing, parity and line break. A global error output shows whether any of them is set. All four flags stay set until a status read, which clears them together. The frame length and parity settings are shared with a companion transmitter. One frame-mode code routes the transmitter output back into the receiver in place of the pin.

The receiver is a single state machine with six states:
- IDLE waits for a low line sample on a tick.
- START checks the start bit at its midpoint.
- DATA collects the data bits.
- PARITY takes the parity bit.
- STOP samples the stop bit.
- HOLD waits for the line to return high after a break.

Transitions:
- IDLE→START on a low sample.
- START→IDLE when the line is high at the midpoint (glitch). START→DATA when it is low.
- DATA→PARITY after the last data bit when parity is in use. DATA→STOP after the last data bit otherwise.
- PARITY→STOP after one bit.
- STOP→IDLE after the stop sample. STOP→HOLD instead when every sample of the frame, stop included, was low.
- HOLD→IDLE on a high sample.

Top module: `serial_rx_sticky`

## Requirements
- R1: `frame_mode` selects the frame length. 2'b00 gives 8 data bits, 2'b01 gives 7 and 2'b10 gives 9. Data arrives LSB first after one low start bit, and `rx_data[7:0]` holds the first eight bits. In 7-bit frames `rx_data[7]` reads 0.
- R2: `buf_full` rises once a character has been stored. It clears in the cycle after a one-cycle `rd_data` pulse.
- R3: A character that completes while `buf_full` is set raises `err_overrun`. The buffer keeps the older character.
- R4: A stop bit sampled low raises `err_frame`.
- R5: A frame whose every sample, stop bit included, is low raises `err_break` together with `err_frame`. After that, no new start is accepted until the line has been sampled high.
- R6: With `par_en` set in 7- or 8-bit frames, one parity bit follows the data. `par_sel` sets the rule: 00 odd, 01 even, 10 always 1, 11 always 0. A mismatch raises `err_parity`.
- R7: In 9-bit frames the ninth data bit appears on `rx_bit9`. No parity bit is expected even when `par_en` is set.
- R8: `frame_mode` 2'b11 takes the line from `tx_loop` instead of `rx_pin` and uses 9-bit framing.
- R9: The four error flags stay set until a one-cycle `rd_status` pulse, which clears all of them together.
- R10: `err_any` is high exactly when at least one of the four error flags is high.
- R11: A start bit that is no longer low at its midpoint, eight ticks after detection, is dropped. It stores nothing and flags nothing.
- R12: `receiving` is high from start detection until the stop bit is sampled.
- R13: After reset all flags, `rx_data`, `rx_bit9` and `receiving` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pin | input | 1 | Serial input pin, idle high |
| tx_loop | input | 1 | Transmitter output used in loopback |
| tick16 | input | 1 | Oversampling tick, sixteen per bit |
| frame_mode | input | 2 | 00 8-bit, 01 7-bit, 10 9-bit, 11 loopback 9-bit |
| par_en | input | 1 | Parity present (7/8-bit only) |
| par_sel | input | 2 | 00 odd, 01 even, 10 mark, 11 space |
| rd_data | input | 1 | Buffer read strobe |
| rd_status | input | 1 | Status read strobe, clears errors |
| rx_data | output | 8 | Received character |
| rx_bit9 | output | 1 | Received ninth bit |
| buf_full | output | 1 | Buffer holds an unread character |
| err_overrun | output | 1 | Sticky overrun flag |
| err_frame | output | 1 | Sticky framing error flag |
| err_parity | output | 1 | Sticky parity error flag |
| err_break | output | 1 | Sticky line break flag |
| err_any | output | 1 | OR of the four error flags |
| receiving | output | 1 | Character in progress |

## Verification
Each frame length is driven with asymmetric data. A bit-order or bit-count mistake therefore shows up as a wrong byte or a misread stop bit. Every parity rule is sent once with a good parity bit and once with a bad one, so a swapped rule cannot pass. In 9-bit frames `par_en` is left set, which exposes a receiver that wrongly waits for a parity bit. Loopback is tested with the pin held low, so a mux fault would read as a break. Stop-low, all-low, back-to-back unread and short-pulse patterns separate framing from break, overrun from a normal load, and a glitch from a real start.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    localparam logic [1:0] FM_EIGHT = 2'b00;
    localparam logic [1:0] FM_SEVEN = 2'b01;
    localparam logic [1:0] FM_NINE  = 2'b10;
    localparam logic [1:0] FM_LOOP  = 2'b11;

    typedef struct packed {
        logic [8:0] data;
        logic       par_bad;
        logic       stop_low;
        logic       all_low;
    } frame_res_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_sel,
    input  logic rx_pin,
    input  logic tx_loop,
    output logic line
);
    logic [STAGES-1:0] sr;
    logic              src;

    assign src = loop_sel ? tx_loop : rx_pin;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '1;
                else        sr <= src;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '1;
                else        sr <= {sr[STAGES-2:0], src};
            end
        end
    endgenerate

    assign line = sr[STAGES-1];
endmodule

// File: rtl/srx_fsm.sv
module srx_fsm
    import srx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic [1:0] frame_mode,
    input  logic       par_en,
    input  logic [1:0] par_sel,
    output logic       receiving,
    output logic       done,
    output frame_res_t res
);
    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2 - 1;

    rx_state_e       state, nxt;
    logic [CW-1:0]   cnt;
    logic [3:0]      bit_idx;
    logic [3:0]      nbits;
    logic [8:0]      shreg;
    logic            par_bit;
    logic            all_low;
    logic            use_par;
    logic            samp;
    logic            ones;
    logic            par_bad;

    always_comb begin
        unique case (frame_mode)
            FM_EIGHT: nbits = 4'd8;
            FM_SEVEN: nbits = 4'd7;
            default:  nbits = 4'd9;
        endcase
    end

    assign use_par = par_en && !frame_mode[1];
    assign samp = tick && ((state == ST_START) ? (cnt == CW'(MID))
                                               : (cnt == CW'(OVS - 1)));
    assign ones = ^shreg[7:0];

    always_comb begin
        unique case (par_sel)
            2'b00:   par_bad = (ones ^ par_bit) != 1'b1;
            2'b01:   par_bad = (ones ^ par_bit) != 1'b0;
            2'b10:   par_bad = !par_bit;
            default: par_bad = par_bit;
        endcase
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (tick && !line) nxt = ST_START;
            ST_START:  if (samp) nxt = line ? ST_IDLE : ST_DATA;
            ST_DATA:   if (samp && bit_idx == nbits - 4'd1)
                           nxt = use_par ? ST_PARITY : ST_STOP;
            ST_PARITY: if (samp) nxt = ST_STOP;
            ST_STOP:   if (samp) nxt = (all_low && !line) ? ST_HOLD : ST_IDLE;
            ST_HOLD:   if (tick && line) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            all_low <= 1'b0;
            done    <= 1'b0;
            res     <= '0;
        end else begin
            done <= 1'b0;
            if (nxt != state || samp) cnt <= '0;
            else if (tick)            cnt <= cnt + 1'b1;

            if (state == ST_IDLE && nxt == ST_START) begin
                shreg   <= '0;
                bit_idx <= '0;
                all_low <= 1'b1;
            end
            if (samp && state == ST_DATA) begin
                shreg[bit_idx] <= line;
                bit_idx        <= bit_idx + 4'd1;
                all_low        <= all_low & !line;
            end
            if (samp && state == ST_PARITY) begin
                par_bit <= line;
                all_low <= all_low & !line;
            end
            if (samp && state == ST_STOP) begin
                done         <= 1'b1;
                res.data     <= shreg;
                res.stop_low <= !line;
                res.all_low  <= all_low & !line;
                res.par_bad  <= use_par & par_bad;
            end
        end
    end

    always_comb begin
        receiving = (state == ST_START) || (state == ST_DATA) ||
                    (state == ST_PARITY) || (state == ST_STOP);
    end
endmodule

// File: rtl/srx_status.sv
module srx_status
    import srx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  frame_res_t    res,
    input  logic          rd_data,
    input  logic          rd_status,
    output logic [DW-1:0] rx_data,
    output logic          rx_bit9,
    output logic          buf_full,
    output logic          err_overrun,
    output logic          err_frame,
    output logic          err_parity,
    output logic          err_break
);
    logic load;
    logic lost;

    assign load = done && (!buf_full || rd_data);
    assign lost = done && buf_full && !rd_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_bit9     <= 1'b0;
            buf_full    <= 1'b0;
            err_overrun <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_break   <= 1'b0;
        end else begin
            if (load) begin
                rx_data  <= res.data[DW-1:0];
                rx_bit9  <= res.data[8];
                buf_full <= 1'b1;
            end else if (rd_data) begin
                buf_full <= 1'b0;
            end
            err_overrun <= lost                     | (err_overrun & !rd_status);
            err_frame   <= (done && res.stop_low)   | (err_frame   & !rd_status);
            err_parity  <= (done && res.par_bad)    | (err_parity  & !rd_status);
            err_break   <= (done && res.all_low)    | (err_break   & !rd_status);
        end
    end
endmodule

// File: rtl/serial_rx_sticky.sv
module serial_rx_sticky
    import srx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_pin,
    input  logic       tx_loop,
    input  logic       tick16,
    input  logic [1:0] frame_mode,
    input  logic       par_en,
    input  logic [1:0] par_sel,
    input  logic       rd_data,
    input  logic       rd_status,
    output logic [7:0] rx_data,
    output logic       rx_bit9,
    output logic       buf_full,
    output logic       err_overrun,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_break,
    output logic       err_any,
    output logic       receiving
);
    logic       line;
    logic       frame_done;
    frame_res_t frame_res;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .loop_sel (frame_mode == FM_LOOP),
        .rx_pin   (rx_pin),
        .tx_loop  (tx_loop),
        .line     (line)
    );

    srx_fsm #(.OVS(OVS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .line       (line),
        .frame_mode (frame_mode),
        .par_en     (par_en),
        .par_sel    (par_sel),
        .receiving  (receiving),
        .done       (frame_done),
        .res        (frame_res)
    );

    srx_status #(.DW(8)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (frame_done),
        .res         (frame_res),
        .rd_data     (rd_data),
        .rd_status   (rd_status),
        .rx_data     (rx_data),
        .rx_bit9     (rx_bit9),
        .buf_full    (buf_full),
        .err_overrun (err_overrun),
        .err_frame   (err_frame),
        .err_parity  (err_parity),
        .err_break   (err_break)
    );

    assign err_any = err_overrun | err_frame | err_parity | err_break;
endmodule

// File: rtl/srx_chk.sv
module srx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_data,
    input logic       rd_status,
    input logic [7:0] rx_data,
    input logic       rx_bit9,
    input logic       buf_full,
    input logic       err_overrun,
    input logic       err_frame,
    input logic       err_parity,
    input logic       err_break,
    input logic       err_any,
    input logic       receiving,
    input logic       frame_done
);
    p_full_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> buf_full);

    p_full_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && !frame_done |=> !buf_full);

    p_keep_old_r3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full && !rd_data |=> $stable(rx_data) && $stable(rx_bit9));

    p_frame_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_frame) |-> $past(frame_done));

    p_break_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_break |-> err_frame);

    p_sticky_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame && !rd_status |=> err_frame);

    p_sticky_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun && !rd_status |=> err_overrun);

    p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status && !frame_done |=> !err_overrun && !err_frame && !err_parity && !err_break);

    p_any_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_any) |-> $past(rd_status));

    p_idle_at_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !receiving);
endmodule

bind serial_rx_sticky srx_chk u_srx_chk (.*);

// File: tb/test_serial_rx_sticky.sv
module test_serial_rx_sticky;
    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_pin = 1'b1;
    logic       tx_loop = 1'b1;
    logic       tick16 = 1'b0;
    logic [1:0] frame_mode = 2'b00;
    logic       par_en = 1'b0;
    logic [1:0] par_sel = 2'b00;
    logic       rd_data = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, buf_full, err_overrun, err_frame, err_parity;
    logic       err_break, err_any, receiving;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    serial_rx_sticky i_serial_rx_sticky (.*);

    always #2.5 clk = ~clk;

    initial begin : tick_gen
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div + 1) % 4;
            tick16 = (div == 0);
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input bit v, input bit lb);
        if (lb) tx_loop = v; else rx_pin = v;
    endtask

    function automatic bit par_of(input logic [7:0] d, input logic [1:0] sel);
        bit o = ^d;
        case (sel)
            2'b00:   return ~o;
            2'b01:   return o;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic send(input logic [8:0] d, input int nb, input bit hp, input bit pb,
                        input bit stopv, input bit lb);
        drive(1'b0, lb); repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            drive(d[i], lb); repeat (BITCLK) @(negedge clk);
        end
        if (hp) begin drive(pb, lb); repeat (BITCLK) @(negedge clk); end
        drive(stopv, lb); repeat (BITCLK) @(negedge clk);
        drive(1'b1, lb); repeat (40) @(negedge clk);
    endtask

    task automatic pulse_rd();
        rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_st();
        rd_status = 1'b1; @(negedge clk); rd_status = 1'b0; @(negedge clk);
    endtask

    task automatic clean();
        pulse_rd(); pulse_st();
    endtask

    task automatic t_reset();
        chk(buf_full, 0, "R13 buf_full");
        chk(err_any, 0, "R13 err_any");
        chk({err_overrun, err_frame, err_parity, err_break}, 0, "R13 flags");
        chk(rx_data, 0, "R13 rx_data");
        chk(receiving, 0, "R13 receiving");
    endtask

    task automatic t_basic8();
        frame_mode = 2'b00; par_en = 1'b0;
        fork
            send(9'h0B4, 8, 0, 0, 1, 0);
            begin repeat (BITCLK + 8) @(negedge clk); chk(receiving, 1, "R12 busy mid"); end
        join
        chk(receiving, 0, "R12 idle after");
        chk(buf_full, 1, "R2 full set");
        chk(rx_data, 8'hB4, "R1 8-bit data");
        chk(err_any, 0, "R10 no error");
        pulse_rd();
        chk(buf_full, 0, "R2 cleared by read");
    endtask

    task automatic t_seven();
        frame_mode = 2'b01; par_en = 1'b1; par_sel = 2'b01;
        send(9'h0E6, 7, 1, par_of(8'h66, 2'b01), 1, 0);
        chk(rx_data, 8'h66, "R1 7-bit data bit7 zero");
        chk(err_parity, 0, "R6 7-bit even ok");
        clean();
    endtask

    task automatic t_parity();
        frame_mode = 2'b00; par_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            par_sel = 2'(s);
            send(9'h0C5, 8, 1, par_of(8'hC5, 2'(s)), 1, 0);
            chk(err_parity, 0, $sformatf("R6 good parity sel=%0d", s));
            chk(rx_data, 8'hC5, "R6 data with parity");
            clean();
            send(9'h0C5, 8, 1, ~par_of(8'hC5, 2'(s)), 1, 0);
            chk(err_parity, 1, $sformatf("R6 bad parity sel=%0d", s));
            chk(err_any, 1, "R10 any on parity");
            clean();
        end
        par_en = 1'b0;
    endtask

    task automatic t_nine();
        frame_mode = 2'b10; par_en = 1'b1; par_sel = 2'b00;
        send(9'h1A5, 9, 0, 0, 1, 0);
        chk(rx_data, 8'hA5, "R7 low byte");
        chk(rx_bit9, 1, "R7 ninth bit");
        chk(err_any, 0, "R7 no parity in 9-bit");
        clean();
        par_en = 1'b0;
    endtask

    task automatic t_loop();
        frame_mode = 2'b11; rx_pin = 1'b0;
        send(9'h05A, 9, 0, 0, 1, 1);
        chk(rx_data, 8'h5A, "R8 loopback data");
        chk(rx_bit9, 0, "R8 loopback bit9");
        chk(err_any, 0, "R8 pin ignored");
        rx_pin = 1'b1; frame_mode = 2'b00;
        repeat (BITCLK) @(negedge clk);
        clean();
    endtask

    task automatic t_overrun();
        frame_mode = 2'b00;
        send(9'h011, 8, 0, 0, 1, 0);
        send(9'h022, 8, 0, 0, 1, 0);
        chk(err_overrun, 1, "R3 overrun set");
        chk(rx_data, 8'h11, "R3 old data kept");
        clean();
        chk(err_overrun, 0, "R9 overrun cleared");
    endtask

    task automatic t_frame();
        frame_mode = 2'b00;
        send(9'h03C, 8, 0, 0, 0, 0);
        repeat (BITCLK) @(negedge clk);
        chk(err_frame, 1, "R4 framing");
        chk(err_break, 0, "R5 not a break");
        pulse_rd();
        send(9'h081, 8, 0, 0, 1, 0);
        chk(err_frame, 1, "R9 sticky after good frame");
        chk(rx_data, 8'h81, "R9 good data after error");
        pulse_st();
        chk(err_any, 0, "R9 status read clears");
        pulse_rd();
    endtask

    task automatic t_break();
        frame_mode = 2'b00;
        rx_pin = 1'b0;
        repeat (BITCLK * 13) @(negedge clk);
        chk(err_break, 1, "R5 break");
        chk(err_frame, 1, "R5 frame with break");
        chk(receiving, 0, "R5 hold while low");
        rx_pin = 1'b1; repeat (BITCLK) @(negedge clk);
        clean();
        send(9'h0F0, 8, 0, 0, 1, 0);
        chk(rx_data, 8'hF0, "R5 resume after high");
        chk(err_any, 0, "R5 clean resume");
        clean();
    endtask

    task automatic t_glitch();
        rx_pin = 1'b0; repeat (16) @(negedge clk);
        rx_pin = 1'b1; repeat (BITCLK * 12) @(negedge clk);
        chk(buf_full, 0, "R11 glitch stores nothing");
        chk(err_any, 0, "R11 glitch flags nothing");
        chk(receiving, 0, "R11 back to idle");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        t_basic8();
        t_seven();
        t_parity();
        t_nine();
        t_loop();
        t_overrun();
        t_frame();
        t_break();
        t_glitch();
        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule